// File: doc/BRIEF.md
# Retriggerable Alarm Output Driver

This block turns qualified motion-detect pulses into a held alarm level and drives it out on two pins of opposite polarity. Each detect pulse loads a countdown with a programmed number of clock ticks, and the alarm stays asserted while that countdown runs. A further detect pulse loads the full count again, so a steady stream of detections keeps the alarm held without a break.

A second, independent path watches an 8-bit digital measurement of the supply. A low-supply flag with hysteresis sets when the code falls below a lower bound. It clears only when the code climbs above a higher bound. While the flag is set, the alarm is forced on whatever the countdown is doing. The final alarm level is registered once and presented as an active-high pin and an active-low pin. The active-low pin is the one that sinks when the alarm is on.

Top module: `alarm_hold_drv`

## Requirements
- R1: While reset is held, and after its release until a supply sample above the exit bound has been taken, `alarm_o` is 1 and `alarm_sink_n_o` is 0.
- R2: A detect pulse sampled at clock edge E0 with a duration of D ticks (D at least 1) drives `alarm_o` high from edge E1 through edge E(D). It returns low at edge E(D+1), provided no other cause is active.
- R3: A detect pulse that arrives while the countdown is running reloads it to the full duration. The alarm then ends D+1 edges after the latest detect edge.
- R4: With a duration of 0, a detect pulse raises `alarm_o` for exactly one cycle, from edge E1 to edge E2.
- R5: The low-supply flag sets when a sampled supply code is strictly below `UV_ENTER` (default 94). A code equal to `UV_ENTER` does not set it. The alarm follows one edge after the flag.
- R6: Once set, the low-supply flag clears only when a sampled code is strictly above `UV_EXIT` (default 99). Codes from `UV_ENTER` to `UV_EXIT` inclusive keep the flag in its current state.
- R7: The alarm is the OR of the running countdown and the low-supply flag. A countdown started while the supply is low keeps the alarm held after the flag clears, until the countdown ends.
- R8: `alarm_sink_n_o` is always the complement of `alarm_o`.
- R9: The duration is captured only on a detect pulse. Changing `dur_i` while the countdown runs does not change when the alarm ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| det_i | input | 1 | Qualified detect pulse, one cycle per detection |
| dur_i | input | DUR_W | Alarm hold length in clock ticks, captured on each detect |
| supply_i | input | 8 | Digital supply-level code |
| alarm_o | output | 1 | Alarm level, 1 = alarm on |
| alarm_sink_n_o | output | 1 | Alarm level, 0 = alarm on (sinking) |

## Verification
Both result paths go through two registers, so every cause shows at the pins on the second rising edge after the input is driven. The countdown or low-supply flag updates on the first edge, and the output register follows on the second. A detect driven at one falling edge is therefore first seen high two falling edges later. A D-tick hold is last seen high at falling edge D+1 and low at D+2. A supply code change shows up at the second falling edge after it is applied. The bench drives and samples only on falling edges and counts those edges from each stimulus. It checks the edge just before each expected change as well as the edge of the change itself, so an early or late transition is caught.

// File: rtl/alarm_pkg.sv
// Package: alarm_pkg
// Shared types for the alarm output driver. The supply measurement is an
// unsigned code; larger codes mean a higher supply voltage.
package alarm_pkg;

    localparam int SUPPLY_W = 8;

    typedef logic [SUPPLY_W-1:0] supply_code_t;

    // Alarm cause vector: bit 0 countdown running, bit 1 supply low.
    typedef struct packed {
        logic supply_low;
        logic hold_run;
    } alarm_cause_t;

endpackage

// File: rtl/alarm_dur_timer.sv
// Module: alarm_dur_timer
// Retriggerable hold countdown. Each fire pulse loads the length input; the
// counter then decrements once per clock until it reaches zero. busy_o is
// high while the count is non-zero, and also for the cycle right after a fire,
// so a zero length still gives one busy cycle.
// Assumes: fire_i is synchronous to clk; len_i need only be valid with fire_i.
module alarm_dur_timer #(
    parameter int DUR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic [DUR_W-1:0] len_i,
    output logic             busy_o
);

    localparam logic [DUR_W-1:0] ONE  = {{(DUR_W-1){1'b0}}, 1'b1};
    localparam logic [DUR_W-1:0] ZERO = '0;

    logic [DUR_W-1:0] cnt_q;
    logic             hit_q;

    // Load on fire, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
            hit_q <= 1'b0;
        end else begin
            hit_q <= fire_i;
            if (fire_i) begin
                cnt_q <= len_i;
            end else if (cnt_q != ZERO) begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    // Busy whenever the count is live or a fire was just taken.
    always_comb begin
        busy_o = hit_q | (cnt_q != ZERO);
    end

    // R3 / R9: a fire captures the length presented with it.
    a_r3_reload_full: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> (cnt_q == $past(len_i)));

    // R2: a count above one without a new fire keeps busy on the next cycle.
    a_r2_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire_i && cnt_q > ONE) |=> busy_o);

    // R4: a fire always yields busy in the following cycle.
    a_r4_fire_busy: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> busy_o);

endmodule

// File: rtl/alarm_uv_mon.sv
// Module: alarm_uv_mon
// Low-supply detector with hysteresis. The flag sets when the sampled code
// is below ENTER_TH and clears only when the sampled code is above EXIT_TH.
// Reset sets the flag, so the supply is treated as low until proven good.
// Assumes: ENTER_TH < EXIT_TH; the code is sampled every clock.
module alarm_uv_mon
    import alarm_pkg::*;
#(
    parameter supply_code_t ENTER_TH = 8'd94,
    parameter supply_code_t EXIT_TH  = 8'd99
) (
    input  logic         clk,
    input  logic         rst_n,
    input  supply_code_t code_i,
    output logic         low_o
);

    logic low_q;

    // Hysteresis flag: set below the enter bound, clear above the exit bound.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= 1'b1;
        end else if (low_q) begin
            if (code_i > EXIT_TH) begin
                low_q <= 1'b0;
            end
        end else begin
            if (code_i < ENTER_TH) begin
                low_q <= 1'b1;
            end
        end
    end

    always_comb begin
        low_o = low_q;
    end

    // R5: the flag only rises after a sample below the enter bound.
    a_r5_enter_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_q) |-> ($past(code_i) < ENTER_TH));

    // R6: the flag only falls after a sample above the exit bound.
    a_r6_exit_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(low_q) |-> ($past(code_i) > EXIT_TH));

    // R6: inside the band the flag keeps its value.
    a_r6_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (code_i >= ENTER_TH && code_i <= EXIT_TH) |=> $stable(low_q));

endmodule

// File: rtl/alarm_out_stage.sv
// Module: alarm_out_stage
// Merges the alarm causes and registers the result once. Both pins come from
// the same flop, so they change on the same edge with opposite polarity.
// Assumes: reset shows the alarm on, matching the low-supply reset state.
module alarm_out_stage
    import alarm_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  alarm_cause_t cause_i,
    output logic         alarm_o,
    output logic         alarm_sink_n_o
);

    logic alarm_q;

    // Register the OR of all active causes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= 1'b1;
        end else begin
            alarm_q <= |cause_i;
        end
    end

    // Drive true and complementary levels.
    always_comb begin
        alarm_o        = alarm_q;
        alarm_sink_n_o = ~alarm_q;
    end

    // R7: any active cause shows on the next cycle.
    a_r7_cause_to_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_i != '0) |=> alarm_o);

    // R7: with no cause the alarm drops on the next cycle.
    a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_i == '0) |=> !alarm_o);

endmodule

// File: rtl/alarm_hold_drv.sv
// Module: alarm_hold_drv
// Alarm output driver: a retriggerable hold countdown started by detect
// pulses, ORed with a low-supply flag with hysteresis, registered onto an
// active-high and an active-low pin.
// Assumes: det_i is a clean one-cycle pulse per detection; supply_i is an
// unsigned code where larger means higher supply.
module alarm_hold_drv
    import alarm_pkg::*;
#(
    parameter int           DUR_W    = 32,
    parameter supply_code_t UV_ENTER = 8'd94,
    parameter supply_code_t UV_EXIT  = 8'd99
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             det_i,
    input  logic [DUR_W-1:0] dur_i,
    input  logic [7:0]       supply_i,
    output logic             alarm_o,
    output logic             alarm_sink_n_o
);

    logic         hold_busy;
    logic         supply_low;
    alarm_cause_t cause;

    alarm_dur_timer #(
        .DUR_W (DUR_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (det_i),
        .len_i  (dur_i),
        .busy_o (hold_busy)
    );

    alarm_uv_mon #(
        .ENTER_TH (UV_ENTER),
        .EXIT_TH  (UV_EXIT)
    ) u_uv (
        .clk    (clk),
        .rst_n  (rst_n),
        .code_i (supply_code_t'(supply_i)),
        .low_o  (supply_low)
    );

    // Collect the alarm causes.
    always_comb begin
        cause.hold_run   = hold_busy;
        cause.supply_low = supply_low;
    end

    alarm_out_stage u_out (
        .clk            (clk),
        .rst_n          (rst_n),
        .cause_i        (cause),
        .alarm_o        (alarm_o),
        .alarm_sink_n_o (alarm_sink_n_o)
    );

    // R2: a detect shows at the pins two edges later.
    a_r2_detect_to_pin: assert property (@(posedge clk) disable iff (!rst_n)
        det_i |-> ##2 alarm_o);

    // R1: the alarm stays on while the supply has not yet been seen good.
    a_r1_low_forces: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> alarm_o);

endmodule

// File: tb/alarm_hold_drv_tb.sv
// Directed bench for alarm_hold_drv. Inputs are driven and outputs sampled on
// falling edges; a stimulus driven at one falling edge shows at the pins two
// falling edges later.
module alarm_hold_drv_tb;

    localparam int DUR_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             det_i = 1'b0;
    logic [DUR_W-1:0] dur_i = '0;
    logic [7:0]       supply_i = 8'd200;
    logic             alarm_o;
    logic             alarm_sink_n_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    alarm_hold_drv #(
        .DUR_W    (DUR_W),
        .UV_ENTER (8'd94),
        .UV_EXIT  (8'd99)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .det_i          (det_i),
        .dur_i          (dur_i),
        .supply_i       (supply_i),
        .alarm_o        (alarm_o),
        .alarm_sink_n_o (alarm_sink_n_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Compare both pins against the expected alarm level (R8 on the second pin).
    task automatic expect_alarm(input string req, input logic exp);
        n_chk++;
        if (alarm_o !== exp) begin
            n_fail++;
            $display("FAIL %s: alarm_o actual=%b expected=%b at %0t", req, alarm_o, exp, $time);
        end
        n_chk++;
        if (alarm_sink_n_o !== ~exp) begin
            n_fail++;
            $display("FAIL R8: alarm_sink_n_o actual=%b expected=%b at %0t", alarm_sink_n_o, ~exp, $time);
        end
    endtask

    // R1: reset state and release.
    task automatic t_reset();
        tick(3);
        expect_alarm("R1 in reset", 1'b1);
        rst_n = 1'b1;
        tick(1);
        expect_alarm("R1 before first good sample shows", 1'b1);
        tick(1);
        expect_alarm("R1 cleared after good sample", 1'b0);
        tick(2);
    endtask

    // R2 / R4: single detect with length d.
    task automatic t_pulse(input string req, input int d);
        int hold;
        hold = (d == 0) ? 1 : d;
        det_i = 1'b1;
        dur_i = DUR_W'(d);
        tick(1);
        det_i = 1'b0;
        for (int i = 2; i <= hold + 1; i++) begin
            tick(1);
            expect_alarm(req, 1'b1);
        end
        tick(1);
        expect_alarm(req, 1'b0);
        tick(2);
    endtask

    // R3: second detect three cycles after the first reloads the hold.
    task automatic t_retrigger();
        det_i = 1'b1;
        dur_i = DUR_W'(6);
        tick(1);
        det_i = 1'b0;
        tick(2);
        det_i = 1'b1;
        tick(1);
        det_i = 1'b0;
        for (int i = 4; i <= 10; i++) begin
            expect_alarm("R3 held after reload", 1'b1);
            tick(1);
        end
        expect_alarm("R3 ends after reload", 1'b0);
        tick(2);
    endtask

    // R9: changing the length mid-hold has no effect.
    task automatic t_len_change();
        det_i = 1'b1;
        dur_i = DUR_W'(4);
        tick(1);
        det_i = 1'b0;
        dur_i = DUR_W'(20);
        tick(4);
        expect_alarm("R9 last hold cycle", 1'b1);
        tick(1);
        expect_alarm("R9 ends at captured length", 1'b0);
        tick(2);
    endtask

    // R5 / R6: hysteresis on the supply code.
    task automatic t_supply();
        supply_i = 8'd94;
        tick(3);
        expect_alarm("R5 equal to enter bound ignored", 1'b0);
        supply_i = 8'd93;
        tick(1);
        expect_alarm("R5 one edge before entry shows", 1'b0);
        tick(1);
        expect_alarm("R5 entered below bound", 1'b1);
        supply_i = 8'd96;
        tick(3);
        expect_alarm("R6 in band keeps low state", 1'b1);
        supply_i = 8'd99;
        tick(3);
        expect_alarm("R6 equal to exit bound keeps low state", 1'b1);
        supply_i = 8'd100;
        tick(1);
        expect_alarm("R6 one edge before exit shows", 1'b1);
        tick(1);
        expect_alarm("R6 exited above bound", 1'b0);
        supply_i = 8'd97;
        tick(3);
        expect_alarm("R6 in band keeps good state", 1'b0);
        supply_i = 8'd200;
        tick(2);
    endtask

    // R7: hold started during low supply outlasts the flag.
    task automatic t_combined();
        supply_i = 8'd50;
        tick(3);
        expect_alarm("R7 low supply forces alarm", 1'b1);
        det_i = 1'b1;
        dur_i = DUR_W'(10);
        tick(1);
        det_i = 1'b0;
        supply_i = 8'd200;
        tick(10);
        expect_alarm("R7 hold continues after supply good", 1'b1);
        tick(1);
        expect_alarm("R7 alarm ends with hold", 1'b0);
        tick(2);
    endtask

    initial begin
        t_reset();
        t_pulse("R2 hold of 1", 1);
        t_pulse("R2 hold of 5", 5);
        t_pulse("R4 zero length one cycle", 0);
        t_retrigger();
        t_len_change();
        t_supply();
        t_combined();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL all: watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule